// File: doc/BRIEF.md
# Packed half-precision reciprocal square root

This block computes an approximation of 1/sqrt(x) for eight IEEE half-precision lanes packed in a 128-bit word. Each lane decodes its operand and handles the special encodings directly: zeros, infinities, negative values and NaNs. A finite positive input is normalised first, and a subnormal input is normalised through a leading-one search. The unbiased exponent is then folded to an even value, so the square root of the power of two is exact. The significand root is found by a bit-at-a-time search that needs no seed table. The result is rounded to ten fraction bits.

A per-lane write mask decides which lanes take the new value. Masking can be switched off entirely. A lane that is not selected is either cleared or keeps the prior destination lane, depending on the zeroing flag. A broadcast flag feeds lane 0 of the source to every lane. The datapath is a fixed three-stage pipeline that accepts one operand per cycle.

Top module: `hrsqrt_vec`

## Requirements
- R1: For a selected lane with a finite, nonzero, positive input, the relative error of the result against 1/sqrt(x) is below 2^-11 + 2^-14.
- R2: An input equal to exactly 2^(-2n), normal or subnormal, yields exactly 2^n (fraction field zero).
- R3: A positive subnormal input yields a normal result: exponent field neither 0 nor 31, sign bit 0.
- R4: Any input with the sign bit set that is not a zero and not a NaN, negative infinity included, yields 0xFE00.
- R5: Input 0x8000 yields 0xFC00, and input 0x0000 yields 0x7C00.
- R6: Input 0x7C00 yields 0x0000.
- R7: A NaN input (exponent 31, fraction nonzero) yields the same sign, exponent 31, fraction bit 9 forced to 1 and fraction bits 8..0 kept.
- R8: Lane i (bits 16i+15..16i) is selected when mask_en_i is 0 or mask_i[i] is 1, and a selected lane carries the computed value.
- R9: An unselected lane outputs 0x0000 when zero_i is 1.
- R10: An unselected lane outputs the matching lane of dst_i when zero_i is 0.
- R11: With bcast_i set, every lane uses src_i[15:0] as its input.
- R12: valid_o is high exactly 3 cycles after each cycle with valid_i high, and the result belongs to that operand. A new operand may be issued every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operand valid |
| src_i | input | 128 | Packed half-precision source lanes |
| dst_i | input | 128 | Prior destination lanes used for merging |
| mask_i | input | 8 | Per-lane write mask |
| mask_en_i | input | 1 | 1 applies mask_i, 0 selects every lane |
| zero_i | input | 1 | 1 clears unselected lanes, 0 keeps dst_i |
| bcast_i | input | 1 | 1 feeds src_i[15:0] to all lanes |
| valid_o | output | 1 | Result valid |
| res_o | output | 128 | Packed result lanes |

## Verification
Assertions check four properties on every cycle. The valid pipeline has a three-cycle delay. The root found between stages is the largest one whose square times the significand stays within the target, so it is a correct floor. The rounded significand stays normalised. Every selected non-special lane leaves with a normal, positive exponent, and exact powers of four leave with a zero fraction. The relative-error bound against a real-valued reference, the special encodings, and the merge, zero and broadcast choices are shown only by the bench. It checks these on directed corner vectors and on seeded random traffic with gaps and back-to-back issue.

// File: rtl/hrsqrt_pkg.sv
package hrsqrt_pkg;
  localparam int HW    = 16;
  localparam int EW    = 5;
  localparam int MW    = 10;
  localparam int BIAS  = 15;
  localparam int GUARD = 4;
  localparam int YW    = MW + 1 + GUARD;           // root: 1 int + 14 frac bits
  localparam int PW    = 2 * YW + MW + 3;          // product width
  localparam int LAT   = 3;
  localparam logic [PW-1:0] LIMIT = PW'(1) << (2 * (YW - 1) + MW + 2);
  localparam logic [HW-1:0] QNAN_INDEF = 16'hFE00;

  typedef struct packed {
    logic          spec;
    logic [HW-1:0] sval;
    logic [MW+1:0] mp;     // significand, doubled when exponent odd
    logic [EW-1:0] ebase;  // biased result exponent before rounding carry
  } dec_t;

  localparam dec_t DEC_RST = '{spec: 1'b1, sval: '0, mp: '0, ebase: '0};
endpackage

// File: rtl/hrsqrt_decode.sv
module hrsqrt_decode
  import hrsqrt_pkg::*;
(
  input  logic [HW-1:0] h_i,
  output dec_t          dec_o
);
  logic          sgn;
  logic [EW-1:0] ex;
  logic [MW-1:0] fr;
  logic [MW:0]   sig;
  int            msb, e_unb, e_even;

  always_comb begin
    sgn = h_i[HW-1];
    ex  = h_i[HW-2:MW];
    fr  = h_i[MW-1:0];
    msb = 0;
    for (int i = 0; i < MW; i++) if (fr[i]) msb = i;
    if (ex == '0) begin
      sig   = {1'b0, fr} << (MW - msb);
      e_unb = msb - (MW + BIAS - 1);
    end else begin
      sig   = {1'b1, fr};
      e_unb = int'(ex) - BIAS;
    end
    e_even      = e_unb - (e_unb & 1);
    dec_o.mp    = e_unb[0] ? {sig, 1'b0} : {1'b0, sig};
    dec_o.ebase = EW'(BIAS - 1 - (e_even >>> 1));
    dec_o.spec  = 1'b1;
    dec_o.sval  = '0;
    if (ex == '1 && fr != '0)
      dec_o.sval = {sgn, ex, 1'b1, fr[MW-2:0]};
    else if (sgn && h_i[HW-2:0] != '0)
      dec_o.sval = QNAN_INDEF;
    else if (h_i[HW-2:0] == '0)
      dec_o.sval = {sgn, {EW{1'b1}}, {MW{1'b0}}};
    else if (ex == '1)
      dec_o.sval = '0;
    else
      dec_o.spec = 1'b0;
  end
endmodule

// File: rtl/hrsqrt_iter.sv
module hrsqrt_iter
  import hrsqrt_pkg::*;
(
  input  logic [MW+1:0] mp_i,
  output logic [YW-1:0] y_o
);
  logic [YW-1:0] trial;

  // largest y with y^2 * mp <= 4 in fixed point
  always_comb begin
    y_o   = '0;
    trial = '0;
    for (int b = YW - 1; b >= 0; b--) begin
      trial = y_o | (YW'(1) << b);
      if (PW'(trial) * PW'(trial) * PW'(mp_i) <= LIMIT) y_o = trial;
    end
  end
endmodule

// File: rtl/hrsqrt_lane.sv
module hrsqrt_lane
  import hrsqrt_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [HW-1:0] h_i,
  input  logic          sel_i,
  input  logic          zero_i,
  input  logic [HW-1:0] dst_i,
  output logic [HW-1:0] res_o
);
  dec_t          dec, s1_dec, s2_dec;
  logic          s1_sel, s1_zero, s2_sel, s2_zero;
  logic [HW-1:0] s1_dst, s2_dst, nxt;
  logic [YW-1:0] y, s2_y;
  logic [MW+1:0] rnd;
  logic [MW-1:0] mant;
  logic [EW-1:0] expo;

  hrsqrt_decode u_dec (.h_i(h_i), .dec_o(dec));
  hrsqrt_iter   u_iter (.mp_i(s1_dec.mp), .y_o(y));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_dec <= DEC_RST; s1_sel <= 1'b0; s1_zero <= 1'b0; s1_dst <= '0;
      s2_dec <= DEC_RST; s2_sel <= 1'b0; s2_zero <= 1'b0; s2_dst <= '0;
      s2_y   <= '0;      res_o  <= '0;
    end else begin
      s1_dec <= dec;    s1_sel <= sel_i;  s1_zero <= zero_i;  s1_dst <= dst_i;
      s2_dec <= s1_dec; s2_sel <= s1_sel; s2_zero <= s1_zero; s2_dst <= s1_dst;
      s2_y   <= y;      res_o  <= nxt;
    end
  end

  always_comb begin
    rnd  = {1'b0, s2_y[YW-1:GUARD]} + (MW+2)'(s2_y[GUARD-1]);
    mant = rnd[MW+1] ? '0 : rnd[MW-1:0];
    expo = s2_dec.ebase + EW'(rnd[MW+1]);
    if (!s2_sel)          nxt = s2_zero ? '0 : s2_dst;
    else if (s2_dec.spec) nxt = s2_dec.sval;
    else                  nxt = {1'b0, expo, mant};
  end

  p_floor_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !s2_dec.spec |-> (PW'(s2_y) * PW'(s2_y) * PW'(s2_dec.mp) <= LIMIT));
  p_tight_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!s2_dec.spec && s2_y != '1) |->
      ((PW'(s2_y) + 1) * (PW'(s2_y) + 1) * PW'(s2_dec.mp) > LIMIT));
  p_rnd_norm_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !s2_dec.spec |-> (rnd[MW+1] || rnd[MW]));
  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!s2_dec.spec && s2_sel) |=>
      (res_o[HW-1] == 1'b0 && res_o[HW-2:MW] != '0 && res_o[HW-2:MW] != '1));
  p_pow4_exact_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!s2_dec.spec && s2_sel && s2_dec.mp == (MW+2)'(1 << MW)) |=> res_o[MW-1:0] == '0);
endmodule

// File: rtl/hrsqrt_vec.sv
module hrsqrt_vec
  import hrsqrt_pkg::*;
#(
  parameter int LANES = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic [LANES*16-1:0] src_i,
  input  logic [LANES*16-1:0] dst_i,
  input  logic [LANES-1:0]    mask_i,
  input  logic                mask_en_i,
  input  logic                zero_i,
  input  logic                bcast_i,
  output logic                valid_o,
  output logic [LANES*16-1:0] res_o
);
  logic [LAT-1:0] vld_q;
  logic [1:0]     age_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      age_q <= '0;
    end else begin
      vld_q <= {vld_q[LAT-2:0], valid_i};
      if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end
  end
  assign valid_o = vld_q[LAT-1];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [HW-1:0] lane_in;
    logic          lane_sel;
    assign lane_in  = bcast_i ? src_i[HW-1:0] : src_i[g*HW +: HW];
    assign lane_sel = !mask_en_i || mask_i[g];
    hrsqrt_lane u_lane (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .h_i   (lane_in),
      .sel_i (lane_sel),
      .zero_i(zero_i),
      .dst_i (dst_i[g*HW +: HW]),
      .res_o (res_o[g*HW +: HW])
    );
  end

  p_latency_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd3) |-> (valid_o == $past(valid_i, 3)));
endmodule

// File: tb/hrsqrt_vec_tb_top.sv
`timescale 1ns/1ps
module hrsqrt_vec_tb_top;
  localparam int L = 8;
  localparam real BOUND = 0.00054931640625;

  logic clk = 0, rst_n = 0, valid_i = 0, men = 0, zr = 0, bc = 0;
  logic [L*16-1:0] src = '0, dst = '0;
  logic [L-1:0] msk = '0;
  logic valid_o;
  logic [L*16-1:0] res_o;

  hrsqrt_vec dut_i (.clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .src_i(src), .dst_i(dst),
    .mask_i(msk), .mask_en_i(men), .zero_i(zr), .bcast_i(bc), .valid_o(valid_o), .res_o(res_o));

  always #4 clk = ~clk;

  int total = 0, bad = 0, wr = 0, rd = 0, cyc = 0;
  logic [L*16-1:0] op_src [512], op_dst [512];
  logic [L-1:0] op_msk [512];
  bit op_men [512], op_zr [512], op_bc [512];
  int op_cyc [512];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string tag, logic [15:0] act, logic [15:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic real p2(int e);
    real r = 1.0;
    if (e >= 0) for (int i = 0; i < e; i++) r = r * 2.0;
    else for (int i = 0; i < -e; i++) r = r / 2.0;
    return r;
  endfunction

  function automatic real h2r(logic [15:0] h);
    if (h[14:10] == 0) return real'(h[9:0]) * p2(-24);
    return real'(1024 + h[9:0]) * p2(int'(h[14:10]) - 25);
  endfunction

  task automatic check_lane(int k, int l);
    logic [15:0] h, got, exp;
    bit sel;
    string t;
    int e, p;
    real x, ref_v, rel;
    h   = op_bc[k] ? op_src[k][15:0] : op_src[k][l*16 +: 16];
    sel = !op_men[k] || op_msk[k][l];
    got = res_o[l*16 +: 16];
    t   = op_bc[k] ? "R11" : (op_men[k] ? "R8" : "sel");
    if (!sel) begin
      exp = op_zr[k] ? 16'h0000 : op_dst[k][l*16 +: 16];
      chk(got == exp, op_zr[k] ? "R9 zeroed lane" : "R10 merged lane", got, exp);
    end else if (h[14:10] == 5'h1f && h[9:0] != 0) begin
      exp = {h[15], 5'h1f, 1'b1, h[8:0]};
      chk(got == exp, {"R7 nan ", t}, got, exp);
    end else if (h[14:0] == 0) begin
      exp = {h[15], 5'h1f, 10'h0};
      chk(got == exp, {"R5 zero ", t}, got, exp);
    end else if (h[15]) begin
      chk(got == 16'hFE00, {"R4 negative ", t}, got, 16'hFE00);
    end else if (h[14:10] == 5'h1f) begin
      chk(got == 16'h0000, {"R6 inf ", t}, got, 16'h0000);
    end else begin
      x = h2r(h);
      ref_v = 1.0 / $sqrt(x);
      rel = (h2r(got) - ref_v) / ref_v;
      if (rel < 0.0) rel = -rel;
      total++;
      if (got[15] || got[14:10] == 5'h1f || !(rel < BOUND)) begin
        bad++;
        $display("FAIL R1 %s in=%h act=%h rel=%e exp_ref=%e", t, h, got, rel, ref_v);
      end
      if (h[14:10] == 0) begin
        p = 0;
        for (int i = 0; i < 10; i++) if (h[i]) p = i;
        e = p - 24;
        chk(got[14:10] != 0 && got[14:10] != 5'h1f && !got[15], "R3 subnormal", got, 16'h3c00);
        if ($countones(h[9:0]) == 1 && (e % 2) == 0)
          chk(got == {1'b0, 5'(15 - e / 2), 10'h0}, "R2 pow4 sub", got, {1'b0, 5'(15 - e / 2), 10'h0});
      end else begin
        e = int'(h[14:10]) - 15;
        if (h[9:0] == 0 && (e % 2) == 0)
          chk(got == {1'b0, 5'(15 - e / 2), 10'h0}, "R2 pow4", got, {1'b0, 5'(15 - e / 2), 10'h0});
      end
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && valid_o) begin
      if (rd >= wr) chk(1'b0, "R12 spurious valid", 16'(rd), 16'(wr));
      else begin
        chk(cyc - op_cyc[rd] == 3, "R12 latency", 16'(cyc - op_cyc[rd]), 16'd3);
        for (int l = 0; l < L; l++) check_lane(rd, l);
        rd++;
      end
    end
  end

  task automatic issue(logic [L*16-1:0] s, logic [L*16-1:0] d, logic [L-1:0] m, bit me, bit z, bit b);
    @(negedge clk);
    valid_i = 1; src = s; dst = d; msk = m; men = me; zr = z; bc = b;
    op_src[wr] = s; op_dst[wr] = d; op_msk[wr] = m;
    op_men[wr] = me; op_zr[wr] = z; op_bc[wr] = b; op_cyc[wr] = cyc;
    wr++;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      valid_i = 0;
    end
  endtask

  function automatic logic [15:0] rnd_h();
    logic [15:0] sp [6] = '{16'h0000, 16'h8000, 16'h7C00, 16'hFC00, 16'h7D55, 16'hFE01};
    case ($urandom % 12)
      0: return sp[$urandom % 6];
      1, 2: return {6'b0, 10'($urandom) | 10'h1};
      3: return {1'b1, 15'($urandom)};
      4: return {1'b0, 5'(1 + 2 * ($urandom % 15)), 10'h0};
      5: return {6'b0, 10'(1 << (2 * ($urandom % 5)))};
      default: return {1'b0, 5'(1 + $urandom % 30), 10'($urandom)};
    endcase
  endfunction

  function automatic logic [L*16-1:0] rnd_v();
    logic [L*16-1:0] v;
    for (int l = 0; l < L; l++) v[l*16 +: 16] = rnd_h();
    return v;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL R12 watchdog act=%0d exp=%0d", rd, wr);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd1357);
    repeat (3) @(negedge clk);
    total++;
    if (valid_o !== 1'b0 || res_o !== '0) begin
      bad++;
      $display("FAIL reset act=%h exp=0", res_o[15:0]);
    end
    rst_n = 1;
    // R4 R5 R6 R7: specials; R2: 4.0 and 2^-24
    issue({16'h0000, 16'h8000, 16'h7C00, 16'hFC00, 16'h7D23, 16'hBC00, 16'h4400, 16'h0001},
          '0, '0, 0, 0, 0);
    // R3 subnormals, R1 ordinary values
    issue({16'h03FF, 16'h0200, 16'h0155, 16'h3C01, 16'h7BFF, 16'h0400, 16'h3BFF, 16'h5A5A},
          '0, '0, 0, 0, 0);
    // R8 R9 R10 masked merge and zeroing
    issue(rnd_v(), {8{16'hABCD}}, 8'hA5, 1, 0, 0);
    issue(rnd_v(), {8{16'h1234}}, 8'h3C, 1, 1, 0);
    issue(rnd_v(), {8{16'h5555}}, 8'h00, 1, 0, 0);
    // R11 broadcast
    issue({112'h0, 16'h4400}, '0, '0, 0, 0, 1);
    issue({112'h0, 16'h0003}, {8{16'h7777}}, 8'h0F, 1, 0, 1);
    idle(5);
    for (int n = 0; n < 400; n++) begin
      issue(rnd_v(), rnd_v(), 8'($urandom), 1'($urandom), 1'($urandom), ($urandom % 5) == 0);
      if ($urandom % 4 == 0) idle(1 + $urandom % 3);
    end
    idle(8);
    chk(rd == wr, "R12 result count", 16'(rd), 16'(wr));
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule